// File: doc/BRIEF.md
# STS-12 Transmit Section Framer

This block is the byte-wide transmit framer for one STS-12 channel. It sits between core logic that supplies frame-aligned payload bytes and a downstream serializer. Each clock carries one byte of the interleaved 9-row by 1080-column frame. A frame pulse input marks the first byte of a frame. The block then rebuilds the section overhead of each frame. The alignment pattern is always regenerated. The parity byte is recomputed from the previous frame. The eleven slots that follow the parity byte are cleared.

The remaining 36-column overhead comes from one of two sources, chosen by a mode input. In pass mode it is taken unchanged from the parallel bus. In serial mode it is taken from a small buffer that a one-bit strobed port loads one row in advance. Payload columns always pass through. The outgoing frame can be scrambled with the frame-synchronous x^7+x^6+1 sequence. The first 36 bytes of row 1 are never scrambled. Output is registered, with one clock of latency, and comes with a start-of-frame marker.

Top module: `sts12_tx_framer`

## Requirements
- R1: During reset `data_o` and `sof_o` are 0. Every output byte appears exactly one clock after the input byte it derives from. Frame positions advance column by column over 1080 columns and 9 rows, then wrap, starting from row 1 column 1 after reset.
- R2: A `fp_i` pulse forces the byte it accompanies to row 1 column 1, even in mid-frame. `sof_o` is high exactly for the output byte at row 1 column 1.
- R3: In every mode, row 1 columns 1..12 carry 0xF6 and columns 13..24 carry 0x28, whatever `data_i` holds. These bytes are never scrambled.
- R4: Row 1 columns 25..36 are never scrambled. Their source follows the selected overhead mode.
- R5: Row 2 column 1 carries the XOR of all output bytes, as emitted after scrambling, from the previous frame start up to the last byte before the current frame start. Before the first frame start after reset, that XOR starts from zero. This value is inserted before scrambling.
- R6: Row 2 columns 2..12 are forced to 0x00 before scrambling.
- R7: With `mode_i`=0, every byte not named in R3, R5 or R6 takes its value from `data_i`.
- R8: With `mode_i`=1, the overhead bytes in columns 1..36 that are not named in R3, R5 or R6 come from the serial buffer. Payload columns 37..1080 still come from `data_i`. On each `toh_en_i` cycle, serial bit k of a row (k counted from 0) is written to buffer byte k/8 at bit position 7-(k mod 8). Bits after the 288th in a row are ignored. In the last column of each row the buffer is handed over for the next row's overhead and the bit count restarts.
- R9: With `scr_en_i`=1, every byte outside row 1 columns 1..36 is XORed with the scrambler key. The 7-bit state is loaded with all ones at row 1 column 37. Each key bit is state bit 6, taken MSB first, after which the state shifts left and takes in bit6 XOR bit5. With `scr_en_i`=0, bytes leave unscrambled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Frame-aligned input byte |
| fp_i | input | 1 | Frame pulse, high with the first byte of a frame |
| toh_d_i | input | 1 | Serial overhead data bit |
| toh_en_i | input | 1 | Strobe qualifying `toh_d_i` |
| mode_i | input | 1 | Overhead source: 0 parallel bus, 1 serial buffer |
| scr_en_i | input | 1 | Scrambler enable |
| data_o | output | 8 | Framed output byte |
| sof_o | output | 1 | High with the first output byte of a frame |

## Verification
Several properties are checked on every cycle. A frame pulse must be followed by the frame marker, and a marked byte must carry 0xF6. The position counters stay in range. The serial bit count never passes 288 and restarts after each row hand-off. The parity register holds between frame starts, and the scrambler state never locks at zero. With the scrambler off, the cleared slots are zero and payload passes in pass mode. Only the bench scenarios show the following: correct parity values across scrambled and unscrambled frames, the scrambler key sequence, serial overhead landing one row later with its surplus bits dropped, and realignment after a mid-frame pulse.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic {
    TOH_PASS   = 1'b0,
    TOH_SERIAL = 1'b1
  } toh_mode_e;

  localparam byte_t DEF_A1 = 8'hF6;
  localparam byte_t DEF_A2 = 8'h28;
  localparam logic [6:0] SCR_SEED = 7'h7F;

  // one byte of x^7+x^6+1 key, MSB first; returns {next_state, key}
  function automatic logic [14:0] scr_byte(input logic [6:0] st);
    logic [6:0] s;
    byte_t k;
    s = st;
    k = '0;
    for (int i = 0; i < 8; i++) begin
      k[7-i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return {s, k};
  endfunction
endpackage

// File: rtl/sts_pos_gen.sv
module sts_pos_gen #(
  parameter  int ROWS = 9,
  parameter  int COLS = 1080,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fp_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic          row_end_o,
  output logic          frame_start_o
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  assign row_o         = fp_i ? '0 : row_q;
  assign col_o         = fp_i ? '0 : col_q;
  assign row_end_o     = (col_o == COL_LAST);
  assign frame_start_o = (row_o == '0) && (col_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (row_end_o) begin
      col_q <= '0;
      row_q <= (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
    end else begin
      col_q <= col_o + 1'b1;
      row_q <= row_o;
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_q <= ROW_LAST) && (col_q <= COL_LAST)); // R1

  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_end_o && row_o == ROW_LAST && !fp_i) |=> (row_q == '0 && col_q == '0)); // R1
endmodule

// File: rtl/sts_toh_deser.sv
module sts_toh_deser #(
  parameter  int OH_COLS = 36,
  localparam int OH_BITS = OH_COLS * 8,
  localparam int BCW     = $clog2(OH_BITS + 1),
  localparam int IW      = $clog2(OH_COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    byte_o
);
  localparam logic [BCW-1:0] BIT_LIM = BCW'(OH_BITS);

  logic [OH_BITS-1:0] stage_q, active_q;
  logic [BCW-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      active_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      active_q <= stage_q;
      cnt_q    <= '0;
    end else if (en_i && cnt_q < BIT_LIM) begin
      stage_q[BIT_LIM - 1'b1 - cnt_q] <= bit_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < OH_COLS; i++)
      if (idx_i == IW'(i)) byte_o = active_q[OH_BITS-1-8*i -: 8];
  end

  AST_TOH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BIT_LIM); // R8

  AST_TOH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/sts_scrambler.sv
module sts_scrambler
  import sts_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  seed_i,
  output byte_t key_o
);
  logic [6:0]  st_q, st_d;
  logic [14:0] step;

  always_comb begin
    step  = scr_byte(seed_i ? SCR_SEED : st_q);
    st_d  = step[14:8];
    key_o = step[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SCR_SEED;
    else         st_q <= st_d;
  end

  AST_SCR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0); // R9
endmodule

// File: rtl/sts_bip8.sv
module sts_bip8
  import sts_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  byte_t data_i,
  output byte_t b1_o
);
  byte_t acc_q, b1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      b1_q  <= '0;
    end else if (start_i) begin
      b1_q  <= acc_q;
      acc_q <= data_i;
    end else begin
      acc_q <= acc_q ^ data_i;
    end
  end

  assign b1_o = b1_q;

  AST_B1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(b1_q)); // R5
endmodule

// File: rtl/sts12_tx_framer.sv
module sts12_tx_framer
  import sts_pkg::*;
#(
  parameter  int    ROWS    = 9,
  parameter  int    COLS    = 1080,
  parameter  int    N_STS   = 12,
  parameter  int    OH_COLS = 3 * N_STS,
  parameter  byte_t A1      = DEF_A1,
  parameter  byte_t A2      = DEF_A2,
  localparam int    RW      = $clog2(ROWS),
  localparam int    CW      = $clog2(COLS),
  localparam int    IW      = $clog2(OH_COLS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       fp_i,
  input  logic       toh_d_i,
  input  logic       toh_en_i,
  input  logic       mode_i,
  input  logic       scr_en_i,
  output logic [7:0] data_o,
  output logic       sof_o
);
  localparam logic [CW-1:0] C_A2   = CW'(N_STS);
  localparam logic [CW-1:0] C_OHA  = CW'(2 * N_STS);
  localparam logic [CW-1:0] C_OH   = CW'(OH_COLS);

  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic          row_end, frame_start;
  byte_t         toh_byte, key, b1, base, out_byte;
  logic          row_a, row_b, in_oh, no_scr, zero_slot, scr_seed;
  toh_mode_e     mode;

  assign mode = toh_mode_e'(mode_i);

  sts_pos_gen #(.ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk_i, .rst_ni, .fp_i,
    .row_o(row), .col_o(col), .row_end_o(row_end), .frame_start_o(frame_start)
  );

  sts_toh_deser #(.OH_COLS(OH_COLS)) u_toh (
    .clk_i, .rst_ni,
    .bit_i(toh_d_i), .en_i(toh_en_i), .load_i(row_end),
    .idx_i(col[IW-1:0]), .byte_o(toh_byte)
  );

  sts_scrambler u_scr (.clk_i, .rst_ni, .seed_i(scr_seed), .key_o(key));

  sts_bip8 u_bip (.clk_i, .rst_ni, .start_i(frame_start), .data_i(out_byte), .b1_o(b1));

  assign row_a     = (row == RW'(0));
  assign row_b     = (row == RW'(1));
  assign in_oh     = (col < C_OH);
  assign no_scr    = row_a && in_oh;
  assign scr_seed  = row_a && (col == C_OH);
  assign zero_slot = row_b && (col != '0) && (col < C_A2);

  always_comb begin
    if (row_a && col < C_A2)           base = A1;
    else if (row_a && col < C_OHA)     base = A2;
    else if (row_b && col == '0)       base = b1;
    else if (zero_slot)                base = '0;
    else if (in_oh && mode == TOH_SERIAL) base = toh_byte;
    else                               base = data_i;
    out_byte = (scr_en_i && !no_scr) ? (base ^ key) : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      sof_o  <= 1'b0;
    end else begin
      data_o <= out_byte;
      sof_o  <= frame_start;
    end
  end

  AST_FP_SOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> sof_o); // R2

  AST_SOF_A1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (data_o == A1)); // R3

  AST_ZERO_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_slot && !scr_en_i) |=> (data_o == 8'h00)); // R6

  AST_PAYLOAD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_oh && !scr_en_i) |=> (data_o == $past(data_i))); // R7
endmodule

// File: tb/sts12_tx_framer_test.sv
module sts12_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 9, COLS = 1080, OH = 36, OH_BITS = 288;
  localparam int FRAME = ROWS * COLS;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       fp_i = 1'b0, toh_d_i = 1'b0, toh_en_i = 1'b0, mode_i = 1'b0, scr_en_i = 1'b0;
  logic [7:0] data_o;
  logic       sof_o;

  sts12_tx_framer uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct { logic [7:0] d; logic s; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  // model state
  int m_row = 0, m_col = 0, m_cnt = 0, cyc = 0;
  logic [6:0] m_scr = 7'h7F;
  logic [7:0] m_acc = '0, m_b1 = '0;
  logic [OH_BITS-1:0] m_stage = '0, m_active = '0;

  function automatic string tag_of(int r, int c, logic md, logic sc);
    if (r == 0 && c < 24) return "R3";
    if (r == 0 && c < OH) return "R4";
    if (r == 1 && c == 0) return "R5";
    if (r == 1 && c < 12) return "R6";
    if (c < OH && md)     return "R8";
    return sc ? "R9" : "R7";
  endfunction

  task automatic step(input logic fp);
    int r, c, tlen;
    logic [7:0] din, base, key, out;
    logic [6:0] s;
    logic ten, td;
    exp_t e;
    r = fp ? 0 : m_row;
    c = fp ? 0 : m_col;
    din  = 8'(cyc * 37 + (cyc >> 5));
    tlen = (r % 2 == 1) ? 300 : OH_BITS;
    ten  = (c < tlen);
    td   = ^(8'(c * 13 + r * 5 + cyc[12:9]));
    s = (r == 0 && c == OH) ? 7'h7F : m_scr;
    for (int i = 0; i < 8; i++) begin
      key[7-i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    if (r == 0 && c < 12)        base = 8'hF6;
    else if (r == 0 && c < 24)   base = 8'h28;
    else if (r == 1 && c == 0)   base = m_b1;
    else if (r == 1 && c < 12)   base = 8'h00;
    else if (c < OH && mode_i)   base = m_active[OH_BITS-1-8*c -: 8];
    else                         base = din;
    out = (scr_en_i && !(r == 0 && c < OH)) ? base ^ key : base;
    e.d = out; e.s = (r == 0 && c == 0); e.tag = tag_of(r, c, mode_i, scr_en_i);
    q.push_back(e);
    m_scr = s;
    if (r == 0 && c == 0) begin m_b1 = m_acc; m_acc = out; end
    else m_acc = m_acc ^ out;
    if (c == COLS - 1) begin m_active = m_stage; m_cnt = 0; end
    else if (ten && m_cnt < OH_BITS) begin m_stage[OH_BITS-1-m_cnt] = td; m_cnt++; end
    if (c == COLS - 1) begin m_col = 0; m_row = (r == ROWS - 1) ? 0 : r + 1; end
    else begin m_col = c + 1; m_row = r; end
    data_i = din; fp_i = fp; toh_en_i = ten; toh_d_i = td;
    cyc++;
    @(negedge clk_i);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  // monitor: samples a quarter period after each rising edge
  always @(posedge clk_i) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (data_o !== e.d) begin
        errors++;
        $display("FAIL %s: data_o=%02h expected %02h", e.tag, data_o, e.d);
      end
      checks++;
      if (sof_o !== e.s) begin
        errors++;
        $display("FAIL R2: sof_o=%0b expected %0b", sof_o, e.s);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run incomplete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    checks++;
    if (data_o !== 8'h00 || sof_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs %02h/%0b expected 00/0", data_o, sof_o);
    end
    rst_ni = 1'b1;
    // R1 R7: pass mode, no scrambling, starting without a pulse
    mode_i = 1'b0; scr_en_i = 1'b0;
    run(FRAME);
    step(1'b1);
    run(FRAME - 1);
    // R9 R5: scrambled pass mode
    scr_en_i = 1'b1;
    run(2 * FRAME);
    // R8: serial overhead, scrambled
    mode_i = 1'b1;
    run(FRAME);
    // R8 R2: serial, unscrambled, mid-frame realignment
    scr_en_i = 1'b0;
    run(3001);
    step(1'b1);
    run(FRAME + 1200);
    fp_i = 1'b0; toh_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule